// File: doc/BRIEF.md
# Timed Reset Sequencer Channel

This block generates one reset and one clock-stop signal for a single target. Software writes a small control register to raise a reset request. The block then runs a timed sequence. It stops the target clock, drives reset for an apply window, and releases reset while the clock is still stopped for a removal window. It then lets the clock run again. Both windows are counted in strobes on a `tick` input, which the surrounding chip pulses once every quarter microsecond.

A parameter selects one of five target kinds:

| Kind | Request bit | Write-enable bit | Done flag | Output polarity |
|------|-------------|------------------|-----------|-----------------|
| CPU auto-clear | cleared by hardware | yes | yes | active high |
| CPU manual-clear | held until software writes it back | yes | yes | active high |
| Cache flush | cleared when the flush-complete input rises | yes | no | active high |
| Hardware auto-clear | cleared by hardware | no | yes | active high |
| Software manual-clear | held until software writes it back | no | no | chosen by parameter |

State machine:

- States: IDLE, STOP, APPLY, HOLD, RESTOP, REMOVE, FLUSH.
- Transitions:
  - IDLE to STOP on a request, or IDLE to FLUSH on a request for the flush kind.
  - STOP to APPLY after one cycle.
  - APPLY to REMOVE (auto kinds) or to HOLD (manual kinds) once the apply count is reached.
  - HOLD to RESTOP when software clears the request.
  - RESTOP to REMOVE after one cycle.
  - REMOVE to IDLE once the removal count is reached.
  - FLUSH to IDLE when flush-complete is high.

Top module: `rst_seq_channel`

## Requirements
- R1: After reset, `clk_stop` is 0, `rst_out` is at its inactive level, and both registers read 0.
- R2: The control register is at address 0. Its fields are: bit 0 is the request, bit 1 is the write-enable (it always reads 0), and bit 2 is the done flag. The timing register is at address 1. Bits [7:0] hold the apply count and bits [15:8] hold the removal count. Each field keeps 8 bits for the hardware auto-clear kind and 4 bits for every other kind. Bits that are not kept read 0.
- R3: For the two CPU kinds and the flush kind, a control write changes the request only when bit 1 is set in the same write. For the hardware auto-clear and software manual-clear kinds, bit 0 is taken whatever bit 1 holds.
- R4: For the auto kinds, a request visible after write edge E0 produces the following. After E1, `clk_stop` is 1. After E2, reset is also asserted, with apply count P. After E(3+P), reset is released while `clk_stop` stays 1. With removal count Q, after E(4+P+Q) `clk_stop` is 0, the request reads 0 and done reads 1.
- R5: A window with count N ends only after N tick strobes have been sampled in it. A count of 0 gives a one-cycle window. Without ticks, a window with N>0 never ends.
- R6: The manual kinds follow the same path through the apply window. After it, the clock runs (`clk_stop` 0) while reset stays asserted until the request is written 0. Then there is one cycle with both signals asserted, then the removal window with reset released, then IDLE.
- R7: The flush kind drives `rst_out` high one cycle after the request. It never stops the clock. It releases `rst_out` and clears the request one cycle after flush-complete is sampled high.
- R8: The CPU kinds and the hardware kind set done at the end of the sequence. Writing 1 to bit 2 clears done. Done stays set through a new sequence until it is cleared. The flush and software kinds always read done as 0.
- R9: The software manual-clear kind drives `rst_out` low while asserting when `ACTIVE_LOW` is 1. Every other kind is active high.
- R10: While a sequence is running, writes to the request bit are ignored. The one exception is the HOLD state, where the request may be changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Quarter-microsecond count strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control, 1 timing) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| flush_done | input | 1 | Flush-complete indication (flush kind only) |
| rst_out | output | 1 | Reset to the target |
| clk_stop | output | 1 | Request to stop the target clock |

## Verification
A write takes effect at the edge that samples it, E0.

The outputs then follow these delays:

- The state machine reacts one edge later, so `clk_stop` is due after E1 and reset after E2.
- With a steady tick, an apply count P moves the outputs at E(3+P).
- A removal count Q completes the sequence at E(4+P+Q).
- Manual release takes one cycle through RESTOP before the removal window starts.

The bench drives inputs on the falling edge. It steps an exact number of rising edges from each write and samples on the falling edge. It also holds `tick` low or pulses it for a counted number of edges to pin down where each window ends.

// File: rtl/rstch_pkg.sv
package rstch_pkg;

    typedef enum logic [2:0] {
        KIND_CPU_AUTO,
        KIND_CPU_MANUAL,
        KIND_FLUSH,
        KIND_HW_AUTO,
        KIND_SW_MANUAL
    } rst_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_APPLY,
        ST_HOLD,
        ST_RESTOP,
        ST_REMOVE,
        ST_FLUSH
    } seq_state_e;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_TIME = 1;
    localparam int unsigned BIT_REQ   = 0;
    localparam int unsigned BIT_WE    = 1;
    localparam int unsigned BIT_DONE  = 2;
    localparam int unsigned REMOVE_LSB = 8;

    function automatic bit kind_has_we(rst_kind_e k);
        return (k == KIND_CPU_AUTO) || (k == KIND_CPU_MANUAL) || (k == KIND_FLUSH);
    endfunction

    function automatic bit kind_has_done(rst_kind_e k);
        return (k == KIND_CPU_AUTO) || (k == KIND_CPU_MANUAL) || (k == KIND_HW_AUTO);
    endfunction

    function automatic bit kind_self_clear(rst_kind_e k);
        return (k == KIND_CPU_AUTO) || (k == KIND_FLUSH) || (k == KIND_HW_AUTO);
    endfunction

    function automatic bit kind_manual(rst_kind_e k);
        return (k == KIND_CPU_MANUAL) || (k == KIND_SW_MANUAL);
    endfunction

    function automatic int unsigned kind_period_w(rst_kind_e k);
        return (k == KIND_HW_AUTO) ? 8 : 4;
    endfunction

endpackage

// File: rtl/rstch_timer.sv
module rstch_timer #(
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [PW-1:0] period,
    output logic          expired
);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q >= period);

    AST_CNT_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/rstch_fsm.sv
module rstch_fsm
    import rstch_pkg::*;
#(
    parameter rst_kind_e KIND = KIND_CPU_AUTO
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       flush_done,
    input  logic       phase_exp,
    output seq_state_e state,
    output logic       cnt_clr,
    output logic       rst_int,
    output logic       clk_stop,
    output logic       seq_end,
    output logic       accept_req
);

    localparam bit MANUAL   = kind_manual(KIND);
    localparam bit IS_FLUSH = (KIND == KIND_FLUSH);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        seq_end = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = IS_FLUSH ? ST_FLUSH : ST_STOP;
            ST_STOP:   state_d = ST_APPLY;
            ST_APPLY:  if (phase_exp) state_d = MANUAL ? ST_HOLD : ST_REMOVE;
            ST_HOLD:   if (!req) state_d = ST_RESTOP;
            ST_RESTOP: state_d = ST_REMOVE;
            ST_REMOVE: begin
                if (phase_exp) begin
                    state_d = ST_IDLE;
                    seq_end = 1'b1;
                end
            end
            ST_FLUSH: begin
                if (flush_done) begin
                    state_d = ST_IDLE;
                    seq_end = 1'b1;
                end
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        clk_stop   = 1'b0;
        rst_int    = 1'b0;
        accept_req = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept_req = 1'b1;
            ST_STOP:   clk_stop = 1'b1;
            ST_APPLY:  begin clk_stop = 1'b1; rst_int = 1'b1; end
            ST_HOLD:   begin rst_int = 1'b1; accept_req = 1'b1; end
            ST_RESTOP: begin clk_stop = 1'b1; rst_int = 1'b1; end
            ST_REMOVE: clk_stop = 1'b1;
            ST_FLUSH:  rst_int = 1'b1;
            default:   accept_req = 1'b0;
        endcase
    end

    assign cnt_clr = (state_d != state_q);
    assign state   = state_q;

    generate
        if (!IS_FLUSH) begin : g_stop_checks
            AST_STOP_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_int) |-> $past(clk_stop)); // R4
            AST_STOP_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(rst_int) |-> clk_stop); // R6
        end
        if (MANUAL) begin : g_hold_check
            AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_HOLD && req) |=> rst_int); // R6
        end
    endgenerate

endmodule

// File: rtl/rstch_regs.sv
module rstch_regs
    import rstch_pkg::*;
#(
    parameter rst_kind_e   KIND   = KIND_CPU_AUTO,
    parameter int unsigned PW     = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              accept_req,
    input  logic              seq_end,
    output logic              req,
    output logic [PW-1:0]     apply_p,
    output logic [PW-1:0]     remove_p
);

    localparam bit HAS_WE     = kind_has_we(KIND);
    localparam bit HAS_DONE   = kind_has_done(KIND);
    localparam bit SELF_CLEAR = kind_self_clear(KIND);

    logic ctrl_wr, time_wr, req_write, done_q;

    assign ctrl_wr   = wr && (addr == ADDR_W'(ADDR_CTRL));
    assign time_wr   = wr && (addr == ADDR_W'(ADDR_TIME));
    assign req_write = ctrl_wr && accept_req && (!HAS_WE || wdata[BIT_WE]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req <= 1'b0;
        end else if (seq_end && SELF_CLEAR) begin
            req <= 1'b0;
        end else if (req_write) begin
            req <= wdata[BIT_REQ];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            apply_p  <= '0;
            remove_p <= '0;
        end else if (time_wr) begin
            apply_p  <= wdata[PW-1:0];
            remove_p <= wdata[REMOVE_LSB +: PW];
        end
    end

    generate
        if (HAS_DONE) begin : g_done
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    done_q <= 1'b0;
                end else if (seq_end) begin
                    done_q <= 1'b1;
                end else if (ctrl_wr && wdata[BIT_DONE]) begin
                    done_q <= 1'b0;
                end
            end
            AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (done_q && !(ctrl_wr && wdata[BIT_DONE])) |=> done_q); // R8
        end else begin : g_no_done
            assign done_q = 1'b0;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rdata[BIT_REQ]  = req;
            rdata[BIT_DONE] = done_q;
        end else begin
            rdata[PW-1:0]          = apply_p;
            rdata[REMOVE_LSB +: PW] = remove_p;
        end
    end

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_req && !seq_end) |=> $stable(req)); // R10

endmodule

// File: rtl/rst_seq_channel.sv
module rst_seq_channel
    import rstch_pkg::*;
#(
    parameter rst_kind_e   KIND       = KIND_CPU_AUTO,
    parameter bit          ACTIVE_LOW = 1'b0,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              flush_done,
    output logic              rst_out,
    output logic              clk_stop
);

    localparam int unsigned PW      = kind_period_w(KIND);
    localparam bit          OUT_LOW = (KIND == KIND_SW_MANUAL) && ACTIVE_LOW;

    seq_state_e    state;
    logic          req, accept_req, seq_end, cnt_clr, phase_exp, rst_int;
    logic [PW-1:0] apply_p, remove_p, phase_period;

    rstch_regs #(
        .KIND(KIND), .PW(PW), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .accept_req(accept_req),
        .seq_end(seq_end), .req(req), .apply_p(apply_p), .remove_p(remove_p)
    );

    rstch_fsm #(.KIND(KIND)) i_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .flush_done(flush_done),
        .phase_exp(phase_exp), .state(state), .cnt_clr(cnt_clr),
        .rst_int(rst_int), .clk_stop(clk_stop), .seq_end(seq_end),
        .accept_req(accept_req)
    );

    assign phase_period = (state == ST_REMOVE) ? remove_p : apply_p;

    rstch_timer #(.PW(PW)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr),
        .period(phase_period), .expired(phase_exp)
    );

    assign rst_out = OUT_LOW ? ~rst_int : rst_int;

endmodule

// File: tb/test_rst_seq_channel.sv
module test_rst_seq_channel;
    import rstch_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        fdone = 1'b0;
    logic [4:0]  wr = '0;
    logic [0:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd [5];
    logic [4:0]  ro, so;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_seq_channel #(.KIND(KIND_CPU_AUTO)) i_rst_seq_channel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(wr[0]), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd[0]), .flush_done(fdone),
        .rst_out(ro[0]), .clk_stop(so[0]));
    rst_seq_channel #(.KIND(KIND_CPU_MANUAL)) i_rst_seq_channel_man (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(wr[1]), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd[1]), .flush_done(fdone),
        .rst_out(ro[1]), .clk_stop(so[1]));
    rst_seq_channel #(.KIND(KIND_FLUSH)) i_rst_seq_channel_fl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(wr[2]), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd[2]), .flush_done(fdone),
        .rst_out(ro[2]), .clk_stop(so[2]));
    rst_seq_channel #(.KIND(KIND_HW_AUTO)) i_rst_seq_channel_hw (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(wr[3]), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd[3]), .flush_done(fdone),
        .rst_out(ro[3]), .clk_stop(so[3]));
    rst_seq_channel #(.KIND(KIND_SW_MANUAL), .ACTIVE_LOW(1'b1)) i_rst_seq_channel_sw (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(wr[4]), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd[4]), .flush_done(fdone),
        .rst_out(ro[4]), .clk_stop(so[4]));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input int idx, input logic a, input logic [15:0] d);
        addr = a;
        wdata = d;
        wr[idx] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr[idx] = 1'b0;
    endtask

    task automatic rd_reg(input int idx, input logic a, output logic [15:0] v);
        addr = a;
        #1;
        v = rd[idx];
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int i = 0; i < 5; i++) begin
            chk("R1 clk_stop", 16'(so[i]), 16'h0);
            chk("R1 rst_out", 16'(ro[i]), (i == 4) ? 16'h1 : 16'h0);
            rd_reg(i, 1'b0, v); chk("R1 ctrl", v, 16'h0);
            rd_reg(i, 1'b1, v); chk("R1 timing", v, 16'h0);
        end
    endtask

    task automatic t_widths;
        logic [15:0] v;
        wr_reg(0, 1'b1, 16'hFFFF);
        rd_reg(0, 1'b1, v); chk("R2 4-bit timing", v, 16'h0F0F);
        wr_reg(3, 1'b1, 16'hFFFF);
        rd_reg(3, 1'b1, v); chk("R2 8-bit timing", v, 16'hFFFF);
        wr_reg(0, 1'b0, 16'h0002);
        rd_reg(0, 1'b0, v); chk("R2 we bit reads 0", v, 16'h0);
    endtask

    task automatic t_auto_seq;
        logic [15:0] v;
        tick = 1'b1;
        wr_reg(0, 1'b1, 16'h0302);
        wr_reg(0, 1'b0, 16'h0003);
        chk("R4 idle after E0", 16'(so[0]), 16'h0);
        step(1); chk("R4 stop E1", {so[0], ro[0]}, 2'b10);
        step(1); chk("R4 apply E2", {so[0], ro[0]}, 2'b11);
        step(2); chk("R4 apply E4", {so[0], ro[0]}, 2'b11);
        step(1); chk("R4 remove E5", {so[0], ro[0]}, 2'b10);
        step(3); chk("R4 remove E8", {so[0], ro[0]}, 2'b10);
        step(1); chk("R4 idle E9", {so[0], ro[0]}, 2'b00);
        rd_reg(0, 1'b0, v); chk("R4 done set req clear", v, 16'h4);
    endtask

    task automatic t_we_gate;
        logic [15:0] v;
        wr_reg(0, 1'b0, 16'h0001);
        step(3); chk("R3 no start without we", 16'(so[0]), 16'h0);
        rd_reg(0, 1'b0, v); chk("R3 req unchanged", v, 16'h4);
        wr_reg(3, 1'b1, 16'h0000);
        wr_reg(3, 1'b0, 16'h0001);
        step(1); chk("R3 hw starts without we", 16'(so[3]), 16'h1);
        step(3); chk("R3 hw back idle", {so[3], ro[3]}, 2'b00);
        rd_reg(3, 1'b0, v); chk("R8 hw done", v, 16'h4);
        wr_reg(3, 1'b0, 16'h0004);
        rd_reg(3, 1'b0, v); chk("R8 hw done cleared", v, 16'h0);
    endtask

    task automatic t_tick_stall;
        logic [15:0] v;
        wr_reg(0, 1'b0, 16'h0004);
        rd_reg(0, 1'b0, v); chk("R8 w1c clears done", v, 16'h0);
        tick = 1'b0;
        wr_reg(0, 1'b1, 16'h0002);
        wr_reg(0, 1'b0, 16'h0003);
        step(2); chk("R5 apply entered", {so[0], ro[0]}, 2'b11);
        step(10); chk("R5 stalled without tick", {so[0], ro[0]}, 2'b11);
        tick = 1'b1;
        step(2);
        tick = 1'b0;
        chk("R5 still apply after 2 ticks", {so[0], ro[0]}, 2'b11);
        step(1); chk("R5 remove after count", {so[0], ro[0]}, 2'b10);
        step(1); chk("R5 zero removal one cycle", {so[0], ro[0]}, 2'b00);
    endtask

    task automatic t_done_sticky;
        logic [15:0] v;
        tick = 1'b1;
        wr_reg(0, 1'b1, 16'h0000);
        wr_reg(0, 1'b0, 16'h0003);
        step(2);
        rd_reg(0, 1'b0, v); chk("R8 done kept during new sequence", v, 16'h5);
        step(2);
        rd_reg(0, 1'b0, v); chk("R8 done after second sequence", v, 16'h4);
        wr_reg(0, 1'b0, 16'h0004);
        rd_reg(0, 1'b0, v); chk("R8 done cleared by w1c", v, 16'h0);
    endtask

    task automatic t_manual;
        logic [15:0] v;
        tick = 1'b1;
        wr_reg(1, 1'b1, 16'h0101);
        wr_reg(1, 1'b0, 16'h0003);
        step(4); chk("R6 hold clock runs", {so[1], ro[1]}, 2'b01);
        step(5); chk("R6 hold persists", {so[1], ro[1]}, 2'b01);
        wr_reg(1, 1'b0, 16'h0000);
        step(2); chk("R3 clear without we ignored", {so[1], ro[1]}, 2'b01);
        rd_reg(1, 1'b0, v); chk("R3 manual req kept", v, 16'h1);
        wr_reg(1, 1'b0, 16'h0002);
        step(1); chk("R6 restop", {so[1], ro[1]}, 2'b11);
        step(1); chk("R6 remove", {so[1], ro[1]}, 2'b10);
        step(2); chk("R6 idle", {so[1], ro[1]}, 2'b00);
        rd_reg(1, 1'b0, v); chk("R8 manual cpu done", v, 16'h4);
    endtask

    task automatic t_flush;
        logic [15:0] v;
        wr_reg(2, 1'b0, 16'h0001);
        step(2); chk("R3 flush needs we", 16'(ro[2]), 16'h0);
        wr_reg(2, 1'b0, 16'h0003);
        step(1); chk("R7 flush asserted no stop", {so[2], ro[2]}, 2'b01);
        step(5); chk("R7 flush waits", {so[2], ro[2]}, 2'b01);
        fdone = 1'b1;
        step(1);
        fdone = 1'b0;
        chk("R7 flush released", {so[2], ro[2]}, 2'b00);
        rd_reg(2, 1'b0, v); chk("R7 flush req clear no done", v, 16'h0);
    endtask

    task automatic t_hw_busy;
        logic [15:0] v;
        tick = 1'b1;
        wr_reg(3, 1'b1, 16'h0303);
        wr_reg(3, 1'b0, 16'h0001);
        step(2);
        wr_reg(3, 1'b0, 16'h0000);
        chk("R10 still in reset", {so[3], ro[3]}, 2'b11);
        rd_reg(3, 1'b0, v); chk("R10 req write ignored", v, 16'h1);
        step(6); chk("R10 remove E9", {so[3], ro[3]}, 2'b10);
        step(1); chk("R10 idle E10", {so[3], ro[3]}, 2'b00);
        rd_reg(3, 1'b0, v); chk("R10 hw cleared and done", v, 16'h4);
    endtask

    task automatic t_sw_low;
        logic [15:0] v;
        tick = 1'b1;
        wr_reg(4, 1'b1, 16'h0000);
        wr_reg(4, 1'b0, 16'h0001);
        step(2); chk("R9 active low asserted", {so[4], ro[4]}, 2'b10);
        step(1); chk("R9 hold low", {so[4], ro[4]}, 2'b00);
        wr_reg(4, 1'b0, 16'h0000);
        step(1); chk("R6 sw restop", {so[4], ro[4]}, 2'b10);
        step(1); chk("R9 released high", {so[4], ro[4]}, 2'b11);
        step(1); chk("R9 idle high", {so[4], ro[4]}, 2'b01);
        rd_reg(4, 1'b0, v); chk("R8 sw never done", v, 16'h0);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_widths;
        t_auto_seq;
        t_we_gate;
        t_tick_stall;
        t_done_sticky;
        t_manual;
        t_flush;
        t_hw_busy;
        t_sw_low;
        step(2);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule